// File: doc/BRIEF.md
# Fair Binary-Tree Request Arbiter

This block chooses one requester out of N for a single shared memory module. Every memory cycle, which is one clock period, has two phases. In the arbitration phase all requests are raised and the grant settles through combinational logic. In the transfer phase the winner uses the module. The clock edge that closes the cycle commits the fairness state of the arbiter.

The arbiter is a balanced binary tree with log2(N) levels of two-input cells. Each cell ORs its two incoming requests and passes the result up to its parent. It forwards the grant it receives from its parent down to one child.

Each cell holds a small state machine with two states:

- PREFER_LOW: the lower-indexed child wins a tie.
- PREFER_HIGH: the higher-indexed child wins a tie.

The cell has three transitions, taken at the clock edge:

- HOLD: the state is kept when no request through the cell was granted.
- TO_HIGH: taken after the low child was granted, whether it asked alone or won a tie.
- TO_LOW: taken after the high child was granted.

Because of these transitions, the side that was just served always loses the next tie. The root's incoming grant is the external module-available signal.

Top module: `fair_tree_arb`

## Requirements
- R1: A grant bit is high only when the request bit with the same index is high, and at most one grant bit is high at a time.
- R2: When `mod_avail` is high and at least one request is high, exactly one grant bit is high in the same cycle.
- R3: When `mod_avail` is low, all grant bits are low. A cycle with no grant leaves every cell's state unchanged.
- R4: `req_any` is high exactly when at least one request bit is high, whatever the value of `mod_avail`.
- R5: A synchronous reset puts every cell in PREFER_LOW. In the first granted cycle after reset, the lowest-indexed active request wins.
- R6: When all N requests stay high with `mod_avail` high, cycle k after reset grants the leaf whose index is the bit-reversal of (k mod N) over log2(N) bits. Every leaf is therefore granted exactly once in any N consecutive cycles, and no leaf is granted twice in a row.
- R7: After a granted cycle, every cell on the path to the granted leaf prefers the side away from that leaf. Example: after reset, a single grant to leaf w is followed, under all-request, by a grant to leaf N/2 if w < N/2, and to leaf 0 otherwise.
- R8: When exactly two leaves a < b request continuously with `mod_avail` high, starting from reset, the grants alternate a, b, a, b, and so on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Memory-cycle clock. Its rising edge closes the arbitration cycle. |
| rst | input | 1 | Synchronous reset, active high. |
| req | input | N | Request lines; bit j is leaf j. |
| mod_avail | input | 1 | Module available; this is the grant input at the root of the tree. |
| grant | output | N | Grant lines; combinational within the cycle. |
| req_any | output | 1 | Cascaded request out of the root. |

## Verification
The bench builds the arbiter with N = 8, which gives three levels and seven state cells. At this size every one of the 256 request patterns can be applied from reset. Each pattern is applied in three ways: with the module unavailable, then with it available, and then followed by an all-request cycle that shows the state left behind. All 28 two-leaf pairs are run for alternation. A long all-request run covers several full bit-reversed rotations, so every tie-break transition of every cell is reached.

// File: rtl/fair_tree_arb_pkg.sv
`timescale 1ns/1ps
package fair_tree_arb_pkg;
    // Tie-break preference held by one tree cell.
    typedef enum logic {
        PREFER_LOW  = 1'b0,
        PREFER_HIGH = 1'b1
    } tie_pref_e;
endpackage

// File: rtl/fair_tree_cell.sv
`timescale 1ns/1ps
module fair_tree_cell
    import fair_tree_arb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic r_lo,
    input  logic r_hi,
    input  logic g_in,
    output logic r_up,
    output logic g_lo,
    output logic g_hi
);
    tie_pref_e state_q, state_d;
    logic      lo_wins;
    logic      hi_wins;

    // State register: committed at the edge that closes the cycle.
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PREFER_LOW;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs: steer the parent grant to one child.
    always_comb begin
        r_up    = r_lo | r_hi;
        lo_wins = 1'b0;
        hi_wins = 1'b0;
        unique case (state_q)
            PREFER_LOW: begin
                lo_wins = r_lo;
                hi_wins = r_hi & ~r_lo;
            end
            PREFER_HIGH: begin
                hi_wins = r_hi;
                lo_wins = r_lo & ~r_hi;
            end
        endcase
        g_lo = g_in & lo_wins;
        g_hi = g_in & hi_wins;
    end

    // Transitions: HOLD, TO_HIGH, TO_LOW.
    always_comb begin
        state_d = state_q;                      // HOLD
        unique case (state_q)
            PREFER_LOW: begin
                if (g_lo) state_d = PREFER_HIGH;  // TO_HIGH
                else if (g_hi) state_d = PREFER_LOW;
            end
            PREFER_HIGH: begin
                if (g_hi) state_d = PREFER_LOW;   // TO_LOW
                else if (g_lo) state_d = PREFER_HIGH;
            end
        endcase
    end
endmodule

// File: rtl/fair_tree_arb.sv
`timescale 1ns/1ps
module fair_tree_arb #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] req,
    input  logic         mod_avail,
    output logic [N-1:0] grant,
    output logic         req_any
);
    localparam int LEVELS = $clog2(N);
    localparam int NODES  = 2 * N;

    // Heap numbering: node 1 is the root, node i has children 2i and 2i+1,
    // and leaves sit at N..2N-1.
    logic [NODES-1:1] node_req;
    logic [NODES-1:1] node_gnt;

    generate
        if (N < 2 || (1 << LEVELS) != N) begin : g_bad_n
            $error("fair_tree_arb: N must be a power of two of at least 2");
        end
    endgenerate

    assign node_req[NODES-1:N] = req;
    assign node_gnt[1]         = mod_avail;
    assign grant               = node_gnt[NODES-1:N];
    assign req_any             = node_req[1];

    generate
        for (genvar i = 1; i < N; i++) begin : g_cell
            fair_tree_cell u_cell (
                .clk  (clk),
                .rst  (rst),
                .r_lo (node_req[2*i]),
                .r_hi (node_req[2*i+1]),
                .g_in (node_gnt[i]),
                .r_up (node_req[i]),
                .g_lo (node_gnt[2*i]),
                .g_hi (node_gnt[2*i+1])
            );
        end
    endgenerate
endmodule

// File: rtl/fair_tree_arb_chk.sv
`timescale 1ns/1ps
module fair_tree_arb_chk #(
    parameter int N = 8
) (
    input logic         clk,
    input logic         rst,
    input logic [N-1:0] req,
    input logic         mod_avail,
    input logic [N-1:0] grant,
    input logic         req_any
);
    // R1
    grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
        ((grant & ~req) == '0) && $onehot0(grant));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (mod_avail && (req != '0)) |-> ($countones(grant) == 1));

    // R3
    no_avail_chk: assert property (@(posedge clk) disable iff (rst)
        !mod_avail |-> (grant == '0));

    // R4
    req_any_chk: assert property (@(posedge clk) disable iff (rst)
        req_any == (req != '0));

    // R5
    reset_low_first_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && (&req) && mod_avail) |-> grant[0]);

    // R6
    no_repeat_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(&req) && $past(mod_avail) && (&req) && mod_avail)
            |-> (grant != $past(grant)));
endmodule

bind fair_tree_arb fair_tree_arb_chk #(.N(N)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .mod_avail (mod_avail),
    .grant     (grant),
    .req_any   (req_any)
);

// File: tb/fair_tree_arb_test.sv
`timescale 1ns/1ps
module fair_tree_arb_test;
    localparam int N      = 8;
    localparam int LEVELS = $clog2(N);

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] req = '0;
    logic         mod_avail = 1'b0;
    logic [N-1:0] grant;
    logic         req_any;

    int n_cmp = 0;
    int n_bad = 0;

    fair_tree_arb #(.N(N)) uut (
        .clk(clk), .rst(rst), .req(req), .mod_avail(mod_avail),
        .grant(grant), .req_any(req_any)
    );

    always #4 clk = ~clk;   // 125 MHz

    task automatic chk(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b", tag, act, exp);
        end
    endtask

    function automatic int bitrev(input int v);
        int r = 0;
        for (int b = 0; b < LEVELS; b++) r = (r << 1) | ((v >> b) & 1);
        return r;
    endfunction

    // Apply inputs at a falling edge; outputs settle before the next rise.
    task automatic drive(input logic [N-1:0] p, input logic av);
        @(negedge clk);
        rst = 1'b0;
        req = p;
        mod_avail = av;
        #2;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        req = '0;
        mod_avail = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [N-1:0] lowest;
        logic [N-1:0] second;
        // Reset state
        do_reset();
        drive('0, 1'b1);
        chk("R4 reset idle req_any", {{(N-1){1'b0}}, req_any}, '0);
        chk("R1 reset idle grant", grant, '0);

        // Sweep every request pattern from reset
        for (int p = 0; p < (1 << N); p++) begin
            do_reset();
            drive(p[N-1:0], 1'b0);
            chk("R3 unavailable grant", grant, '0);
            chk("R4 req_any", {{(N-1){1'b0}}, req_any}, {{(N-1){1'b0}}, (p != 0)});
            drive(p[N-1:0], 1'b1);
            lowest = p[N-1:0] & (~p[N-1:0] + 1'b1);
            chk("R5 lowest wins after reset", grant, lowest);
            drive('1, 1'b1);
            if (p == 0) second = 1;     // R3: idle cycles kept PREFER_LOW
            else if (lowest < (1 << (N/2))) second = 1 << (N/2);
            else second = 1;
            chk("R7 path flips away from winner", grant, second);
        end

        // Two persistent requesters alternate
        for (int a = 0; a < N; a++) begin
            for (int b = a + 1; b < N; b++) begin
                do_reset();
                for (int k = 0; k < 4; k++) begin
                    drive((1 << a) | (1 << b), 1'b1);
                    chk("R8 pair alternation", grant, (k % 2 == 0) ? (1 << a) : (1 << b));
                end
            end
        end

        // Full rotation under all-request
        do_reset();
        for (int k = 0; k < 3 * N; k++) begin
            drive('1, 1'b1);
            chk("R6 bit-reversed rotation", grant, 1 << bitrev(k % N));
        end

        // Unavailable cycles in the middle of a rotation hold state
        for (int k = 0; k < 3; k++) begin
            drive('1, 1'b0);
            chk("R3 hold while unavailable", grant, '0);
        end
        drive('1, 1'b1);
        chk("R3 rotation resumes", grant, 1 << bitrev((3 * N) % N));

        // Reset in mid-run restores leaf 0 priority
        drive('1, 1'b1);
        do_reset();
        drive('1, 1'b1);
        chk("R5 reset mid-run", grant, 1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule